// File: doc/BRIEF.md
# Memory Status Register Read Sequencer

This block is a command sequencer inside a low-power DDR memory controller. Its one job is to fetch the device's status word. That word carries the vendor identifier, the revision, the refresh multiplier, the bus width type and the density. The sequencer starts on a one-cycle request pulse.

First it closes every bank with a precharge-all command and waits out the precharge time. Next it sends a mode-register load whose bank address selects the status register instead of the mode register. It then pads with no-operation cycles for the required interval and issues a read. When the first data beat comes back after the CAS latency, the sequencer latches it. It then keeps the command bus quiet until the post-read recovery time has passed, and signals completion.

The device always returns the status in a two-beat burst, whatever burst length is programmed. Only the first beat is meaningful; the second beat and any strobe outside the expected slot are discarded. All timings are parameters counted in clock cycles, and each is at least one.

Top module: `lpddr_status_reader`

## Requirements
- R1: After synchronous reset, busy_o and done_o are low, status_o is zero and the command pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) with ba_o and addr_o zero.
- R2: A req_i pulse sampled while idle produces a precharge-all in the next cycle: cs_n=0, ras_n=0, cas_n=1, we_n=0, ba_o=0, addr_o with only bit AP_BIT (default 10) set.
- R3: Exactly T_RP cycles after the precharge-all, a mode-register load is issued: all four command pins low, ba_o=2'b01 (bit 0 set, bit 1 clear) and addr_o all zero.
- R4: Exactly T_SRR cycles after the mode-register load, a read is issued (cs_n=0, ras_n=1, cas_n=0, we_n=1, ba_o=0, addr_o=0). Every cycle between two commands carries NOP.
- R5: The word on rd_data_i is captured when rd_valid_i is high in the cycle that lies CAS_LAT cycles after the read, and it appears on status_o in the following cycle.
- R6: rd_valid_i is ignored in every other cycle, including the second burst beat, strobes before the slot and strobes while idle.
- R7: done_o is high for exactly one cycle, max(T_SRC, CAS_LAT+1) cycles after the read. Only NOPs appear between the read and that cycle. busy_o is high from the cycle after the request through the done cycle.
- R8: A req_i pulse while busy_o is high is ignored; the sequence in progress is unchanged and no extra commands appear.
- R9: status_o holds its value from one capture until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Start pulse for one status read |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| rd_valid_i | input | 1 | Read data beat valid from the physical layer |
| rd_data_i | input | DATA_W | Read data beat |
| status_o | output | DATA_W | Last captured status word |

## Verification
The hardest case to reach from the ports is a stray data strobe that lands in the cycle just before the capture slot, followed by a second beat carrying different data. Only exact timing of the strobe relative to the observed read command exposes a capture window that is off by one. The bench's physical-layer model watches for the read command on the pins and schedules the beats from that cycle. On selected runs it adds a junk strobe one cycle early and a differing second beat. Other runs add strobes while idle and a second request in the middle of a sequence, and the scoreboard rejects any command or word that was not predicted.

// File: rtl/srd_pkg.sv
// Shared types for the status read sequencer.
// Assumes: command encoding follows the common SDRAM truth table.
package srd_pkg;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_LOAD_MODE,
        CMD_READ
    } srd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_LMR,
        ST_WAIT_SRR,
        ST_READ,
        ST_WAIT_SRC,
        ST_DONE
    } srd_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } srd_pins_t;

    function automatic int srd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/srd_gap_timer.sv
// Down-counter that times the gap between two commands.
// A load sets the count; the count then falls by one per cycle down to zero.
// last_o marks the final wait cycle (count equal to one).
// Assumes: loads are not issued while a gap is still counting.
module srd_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         last_o
);

    logic [W-1:0] cnt_q;

    // Purpose: load a new gap or count the current one down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == W'(1));

    // A running count must fall by exactly one each cycle (timing base of R3, R4, R7).
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/srd_cmd_encode.sv
// Maps an abstract command to the active-low command pins, bank and address.
// Assumes: AP_BIT selects the all-banks bit of the precharge address.
module srd_cmd_encode
    import srd_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int AP_BIT = 10
) (
    input  srd_cmd_e           cmd_i,
    output logic               cs_n_o,
    output logic               ras_n_o,
    output logic               cas_n_o,
    output logic               we_n_o,
    output logic [BA_W-1:0]    ba_o,
    output logic [ADDR_W-1:0]  addr_o
);

    localparam logic [ADDR_W-1:0] PRE_ALL_ADDR = ADDR_W'(1) << AP_BIT;
    localparam logic [BA_W-1:0]   SRR_BANK     = BA_W'(1);

    srd_pins_t pins;

    // Purpose: look up the pin pattern, bank and address for each command.
    always_comb begin
        pins   = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        ba_o   = '0;
        addr_o = '0;
        unique case (cmd_i)
            CMD_PRE_ALL: begin
                pins   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                addr_o = PRE_ALL_ADDR;
            end
            CMD_LOAD_MODE: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                ba_o = SRR_BANK;
            end
            CMD_READ: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b0, we_n: 1'b1};
            end
            default: ;
        endcase
    end

    assign cs_n_o  = pins.cs_n;
    assign ras_n_o = pins.ras_n;
    assign cas_n_o = pins.cas_n;
    assign we_n_o  = pins.we_n;

endmodule

// File: rtl/srd_beat_capture.sv
// Tracks an issued read through the CAS latency and latches the first beat.
// A strobe is taken only in the single slot CAS_LAT cycles after the read,
// so the second beat and stray strobes are dropped.
// Assumes: at most one read in flight.
module srd_beat_capture #(
    parameter int DATA_W  = 32,
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              read_issued_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] status_o
);

    logic [CAS_LAT-1:0] pipe_q;
    logic               slot;
    logic [DATA_W-1:0]  status_q;

    generate
        if (CAS_LAT == 1) begin : g_lat_one
            // Purpose: mark the slot one cycle after the read.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= read_issued_i;
            end
        end else begin : g_lat_many
            // Purpose: shift the read marker through the latency stages.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[CAS_LAT-2:0], read_issued_i};
            end
        end
    endgenerate

    assign slot = pipe_q[CAS_LAT-1];

    // Purpose: take the data word only in the capture slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (slot && rd_valid_i) begin
            status_q <= rd_data_i;
        end
    end

    assign status_o = status_q;

    // Only one read may be in flight, so only one slot can open (R6).
    assert_single_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pipe_q));

    // Outside the slot the stored word must not move (R6, R9).
    assert_no_stray_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !slot |=> $stable(status_q));

endmodule

// File: rtl/lpddr_status_reader.sv
// Status register read sequencer for a low-power DDR controller.
// Sequence: precharge-all, wait T_RP, status-select mode load, wait T_SRR,
// read, capture after CAS_LAT, recover until max(T_SRC, CAS_LAT+1), done.
// Assumes: all timings are at least one cycle; requests while busy are ignored.
module lpddr_status_reader
    import srd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 13,
    parameter int BA_W    = 2,
    parameter int AP_BIT  = 10,
    parameter int T_RP    = 3,
    parameter int T_SRR   = 2,
    parameter int T_SRC   = 6,
    parameter int CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BA_W-1:0]   ba_o,
    output logic [ADDR_W-1:0] addr_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] status_o
);

    localparam int DONE_GAP = srd_max(T_SRC, CAS_LAT + 1);
    localparam int GAP_MAX  = srd_max(srd_max(T_RP, T_SRR), DONE_GAP);
    localparam int TW       = $clog2(GAP_MAX + 1);
    localparam int GW       = $clog2(GAP_MAX + 2);

    srd_state_e     state_q, state_d;
    srd_cmd_e       cmd;
    logic           tmr_load;
    logic [TW-1:0]  tmr_val;
    logic           tmr_last;

    // Purpose: advance the sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: choose the next state from the request and the gap timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (req_i) state_d = ST_PRE;
            ST_PRE:      state_d = (T_RP > 1) ? ST_WAIT_RP : ST_LMR;
            ST_WAIT_RP:  if (tmr_last) state_d = ST_LMR;
            ST_LMR:      state_d = (T_SRR > 1) ? ST_WAIT_SRR : ST_READ;
            ST_WAIT_SRR: if (tmr_last) state_d = ST_READ;
            ST_READ:     state_d = (DONE_GAP > 1) ? ST_WAIT_SRC : ST_DONE;
            ST_WAIT_SRC: if (tmr_last) state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Purpose: pick the command for the current state; NOP everywhere else.
    always_comb begin
        unique case (state_q)
            ST_PRE:  cmd = CMD_PRE_ALL;
            ST_LMR:  cmd = CMD_LOAD_MODE;
            ST_READ: cmd = CMD_READ;
            default: cmd = CMD_NOP;
        endcase
    end

    // Purpose: load the gap that must follow each issued command.
    always_comb begin
        tmr_load = 1'b1;
        unique case (state_q)
            ST_PRE:  tmr_val = TW'(T_RP - 1);
            ST_LMR:  tmr_val = TW'(T_SRR - 1);
            ST_READ: tmr_val = TW'(DONE_GAP - 1);
            default: begin
                tmr_load = 1'b0;
                tmr_val  = '0;
            end
        endcase
    end

    srd_gap_timer #(.W(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .last_o     (tmr_last)
    );

    srd_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W), .AP_BIT(AP_BIT)) u_enc (
        .cmd_i   (cmd),
        .cs_n_o  (cs_n_o),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o),
        .ba_o    (ba_o),
        .addr_o  (addr_o)
    );

    srd_beat_capture #(.DATA_W(DATA_W), .CAS_LAT(CAS_LAT)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .read_issued_i (cmd == CMD_READ),
        .rd_valid_i    (rd_valid_i),
        .rd_data_i     (rd_data_i),
        .status_o      (status_o)
    );

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_DONE);

    // ---------------- checker state: spacing between issued commands ----------------
    logic           pin_nop, pin_pre, pin_lmr, pin_rd;
    srd_cmd_e       last_q;
    logic [GW-1:0]  gap_q;

    assign pin_nop = !cs_n_o &&  ras_n_o &&  cas_n_o &&  we_n_o;
    assign pin_pre = !cs_n_o && !ras_n_o &&  cas_n_o && !we_n_o;
    assign pin_lmr = !cs_n_o && !ras_n_o && !cas_n_o && !we_n_o;
    assign pin_rd  = !cs_n_o &&  ras_n_o && !cas_n_o &&  we_n_o;

    // Purpose: remember the last pin-level command and the cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= CMD_NOP;
            gap_q  <= GW'(GAP_MAX);
        end else if (!pin_nop) begin
            last_q <= pin_pre ? CMD_PRE_ALL : (pin_lmr ? CMD_LOAD_MODE : CMD_READ);
            gap_q  <= GW'(1);
        end else if (gap_q < GW'(GAP_MAX)) begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    assert_pre_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_i) |=> pin_pre);

    assert_lmr_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_lmr |-> (last_q == CMD_PRE_ALL && gap_q == GW'(T_RP)));

    assert_lmr_selects_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pin_lmr |-> (ba_o == BA_W'(1) && addr_o == '0));

    assert_read_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pin_rd |-> (last_q == CMD_LOAD_MODE && gap_q == GW'(T_SRR)));

    assert_recovery_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_nop && last_q == CMD_READ) |-> (gap_q >= GW'(T_SRC)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(status_o));

endmodule

// File: tb/lpddr_status_reader_test.sv
// Scoreboard bench: a driver task queues the predicted commands and result,
// a monitor compares every cycle of the pins against that queue.
module lpddr_status_reader_test;

    localparam int DW = 32, AW = 13, BW = 2, APB = 10;
    localparam int TRP = 3, TSRR = 2, TSRC = 6, CL = 3;
    localparam int DGAP = (TSRC > CL + 1) ? TSRC : CL + 1;
    localparam int K_PRE = 1, K_LMR = 2, K_RD = 3, K_DONE = 4;

    typedef struct { int cyc; int kind; logic [DW-1:0] data; } exp_t;

    logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
    logic busy, done, cs_n, ras_n, cas_n, we_n, rd_valid = 1'b0;
    logic [BW-1:0] ba;
    logic [AW-1:0] addr;
    logic [DW-1:0] rd_data = '0, status;

    int cyc = 0, checks = 0, errors = 0;
    exp_t q[$];
    int busy_from = -1, busy_to = -1;
    int rd_cyc = -100;
    logic [DW-1:0] beat1, beat2;
    bit early_junk = 0, idle_junk = 0;

    lpddr_status_reader #(.DATA_W(DW), .ADDR_W(AW), .BA_W(BW), .AP_BIT(APB),
        .T_RP(TRP), .T_SRR(TSRR), .T_SRC(TSRC), .CAS_LAT(CL)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .busy_o(busy), .done_o(done),
        .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .ba_o(ba), .addr_o(addr), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
        .status_o(status));

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", r, cyc, act, exp);
        end
    endtask

    // Driver: pulse a request now and queue the predicted schedule.
    task automatic start_read(input logic [DW-1:0] d1, input logic [DW-1:0] d2, input bit junk);
        int r;
        @(negedge clk);
        r = cyc;
        beat1 = d1; beat2 = d2; early_junk = junk;
        req = 1'b1;
        q.push_back('{r + 1, K_PRE, '0});
        q.push_back('{r + 1 + TRP, K_LMR, '0});
        q.push_back('{r + 1 + TRP + TSRR, K_RD, '0});
        q.push_back('{r + 1 + TRP + TSRR + DGAP, K_DONE, d1});
        busy_from = r + 1;
        busy_to = r + 1 + TRP + TSRR + DGAP;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic wait_drained();
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor and physical-layer model.
    always @(negedge clk) begin
        int obs;
        bit pnop, ppre, plmr, prd;
        if (rst_n) begin
            pnop = !cs_n && ras_n && cas_n && we_n;
            ppre = !cs_n && !ras_n && cas_n && !we_n;
            plmr = !cs_n && !ras_n && !cas_n && !we_n;
            prd  = !cs_n && ras_n && !cas_n && we_n;
            obs = ppre ? K_PRE : plmr ? K_LMR : prd ? K_RD : 0;
            if (!pnop && obs == 0) chk(0, "R4 illegal pin pattern", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
            if (prd) rd_cyc = cyc;
            if (done) begin
                if (obs != 0) chk(0, "R7 done with command", obs, 0);
                obs = K_DONE;
            end
            // R7: busy window
            chk(busy == (cyc >= busy_from && cyc <= busy_to), "R7 busy", busy,
                (cyc >= busy_from && cyc <= busy_to));
            if (q.size() != 0 && q[0].cyc == cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(obs == e.kind, "R2/R3/R4/R7 event kind", obs, e.kind);
                case (e.kind)
                    K_PRE:  chk(ba == 0 && addr == (AW'(1) << APB), "R2 precharge-all address", {ba, addr}, AW'(1) << APB);
                    K_LMR:  chk(ba == 2'b01 && addr == 0, "R3 status select", {ba, addr}, {2'b01, 13'd0});
                    K_RD:   chk(ba == 0 && addr == 0, "R4 read address", {ba, addr}, 0);
                    default: chk(status == e.data, "R5 R6 captured word", status, e.data);
                endcase
            end else if (obs != 0) begin
                chk(0, "R8 unexpected event (NOP expected)", obs, 0);
            end
            // Physical-layer beats scheduled from the observed read.
            if (cyc == rd_cyc + CL) begin
                rd_valid <= 1'b1; rd_data <= beat1;
            end else if (cyc == rd_cyc + CL + 1) begin
                rd_valid <= 1'b1; rd_data <= beat2;
            end else if (early_junk && cyc == rd_cyc + CL - 1) begin
                rd_valid <= 1'b1; rd_data <= 32'hBAD0_0001;
            end else if (idle_junk && !busy) begin
                rd_valid <= 1'b1; rd_data <= 32'hBAD0_0002;
            end else begin
                rd_valid <= 1'b0; rd_data <= '0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R7 sequence hung) actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 NOP pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk(ba == 0 && addr == 0 && status == 0, "R1 bus and status zero", {ba, addr, status}, 0);

        // R2 R3 R4 R5 R7: plain status read
        start_read(32'h0000_3A51, 32'hFFFF_0000, 0);
        wait_drained();
        repeat (2) @(negedge clk);

        // R6: early strobe and differing second beat; R8: request while busy
        start_read(32'h1234_5678, 32'h8765_4321, 1);
        repeat (3) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_drained();

        // R9 R6: word holds while idle strobes arrive
        idle_junk = 1;
        repeat (10) @(negedge clk);
        idle_junk = 0;
        @(negedge clk);
        chk(status == 32'h1234_5678, "R9 status held while idle", status, 32'h1234_5678);
        chk(!done, "R7 done low while idle", done, 0);

        // R5: back-to-back request right after completion
        start_read(32'hCAFE_F00D, 32'h0, 0);
        while (!done) @(negedge clk);
        start_read(32'h0BAD_BEEF, 32'h1, 1);
        wait_drained();
        repeat (3) @(negedge clk);
        chk(status == 32'h0BAD_BEEF, "R9 final status", status, 32'h0BAD_BEEF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule